// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer with a small 16-bit register interface. It divides the system clock down to a slow tick; by default one tick is 0.6 s at 100 MHz. On every tick, while the timer is not halted, a 10-bit counter steps down by one. Software keeps the system alive by writing to the reload register before the count runs out. Each such write restarts the count from a programmable initial value.

Expiry happens in two stages. The first time the count runs out, the block only raises a timeout status flag and starts counting again from the initial value. If the count runs out a second time while that flag is still set, the block raises a second-timeout flag and pulses a system reset request for one cycle. It also latches a boot status flag when that pulse fires. A no-reboot input and a no-reboot control bit can each block the reset request, and the status flags still record the expiry while it is blocked. The control register also holds a halt bit and a bit that toggles when written with 1 and drives nothing.

Top module: `wdt_twostage`

## Requirements
- R1: After reset the timer is halted, the no-reboot control bit is 1, all status flags are 0, and the initial value and the count are both 4. A read of the control register at offset 0x08 returns 0x0801, and `reset_req_o` is low.
- R2: A tick occurs once every `TICK_DIV` clock cycles, counted from the release of reset. On each tick the count drops by exactly one while the timer runs and the count is not zero.
- R3: Bit 11 of the control register at 0x08 is the halt bit. When it is 1 the count holds its value; when it is 0 the count runs. The bit reads back as written.
- R4: Any write to offset 0x00 loads the count with the initial value. A read of 0x00 returns the count in bits [9:0], with bits [15:10] reading as 0.
- R5: The initial value is bits [9:0] of offset 0x12. A write whose low field is 0 to 3 leaves the initial value unchanged. Bits [15:10] of 0x12 store every written value regardless of the low field.
- R6: An expiry is a tick that finds the timer running with a count of 0. When the timeout flag (bit 3 of 0x04) is clear, an expiry sets that flag and reloads the count from the initial value.
- R7: When the timeout flag is already set, an expiry reloads the count and sets the second-timeout flag (bit 1 of 0x06). Unless reboot is suppressed, it also drives `reset_req_o` high for exactly one cycle and sets the boot flag (bit 2 of 0x06).
- R8: While `no_reboot_i` is 1 or bit 0 of 0x08 is 1, `reset_req_o` stays low and the boot flag is not set. The timeout and second-timeout flags still update.
- R9: Writing 1 to the bit of a status flag clears that flag. Writing 0 leaves it unchanged. When a flag is set and cleared in the same cycle, the set wins.
- R10: Bit 8 of 0x08 inverts when the register is written with that bit at 1, keeps its value when written with 0, and affects nothing else.
- R11: Offset 0x0A is a plain 16-bit read/write register. Reads of offsets outside the map return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| no_reboot_i | input | 1 | Reboot suppression input |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with `TICK_DIV` = 4 in place of the 60 000 000 default, keeping the 10-bit count and the minimum load value of 4. This brings a full two-stage expiry, with an initial value of 10, within roughly a hundred cycles. That makes it possible to run the no-reboot-bit case, the no-reboot-input case, the unsuppressed case and the clear-between-expiries case back to back. A short divider also puts tick positions at known cycle numbers after reset, so the bench can check an exact count of three ticks between a release and a re-halt.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_RELOAD = 5'h00;
  localparam logic [ADDR_W-1:0] A_STS1   = 5'h04;
  localparam logic [ADDR_W-1:0] A_STS2   = 5'h06;
  localparam logic [ADDR_W-1:0] A_CTL1   = 5'h08;
  localparam logic [ADDR_W-1:0] A_CTL2   = 5'h0A;
  localparam logic [ADDR_W-1:0] A_INIT   = 5'h12;

  localparam int B_TO   = 3;   // in STS1
  localparam int B_SEC  = 1;   // in STS2
  localparam int B_BOOT = 2;   // in STS2
  localparam int B_NR   = 0;   // in CTL1
  localparam int B_NMI  = 8;   // in CTL1
  localparam int B_HALT = 11;  // in CTL1
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      logic [PW-1:0] cnt_q;
      logic          last;
      assign last = (cnt_q == PW'(DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
      assign tick_o = last;
    end
  endgenerate
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W    = 10,
  parameter int INIT_RST = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic             suppress_i,
  input  logic             clr_to_i,
  input  logic             clr_sec_i,
  input  logic             clr_boot_i,
  output logic [CNT_W-1:0] count_o,
  output logic             to_o,
  output logic             sec_o,
  output logic             boot_o,
  output logic             req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic to_q, sec_q, boot_q, req_q;
  logic step, expire, fire;

  assign step   = tick_i && !halt_i && !reload_i;
  assign expire = step && (cnt_q == '0);
  assign fire   = expire && to_q && !suppress_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_W'(INIT_RST);
      to_q   <= 1'b0;
      sec_q  <= 1'b0;
      boot_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (reload_i || expire) cnt_q <= init_i;
      else if (step)          cnt_q <= cnt_q - 1'b1;
      // set wins over a same-cycle clear
      to_q   <= expire | (to_q & ~clr_to_i);
      sec_q  <= (expire & to_q) | (sec_q & ~clr_sec_i);
      boot_q <= fire | (boot_q & ~clr_boot_i);
      req_q  <= fire;
    end
  end

  assign count_o = cnt_q;
  assign to_o    = to_q;
  assign sec_o   = sec_q;
  assign boot_o  = boot_q;
  assign req_o   = req_q;
endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
  import wdt_pkg::*;
#(
  parameter int unsigned TICK_DIV = 60_000_000,
  parameter int          CNT_W    = 10,
  parameter int          MIN_INIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              we_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              no_reboot_i,
  output logic              reset_req_o
);
  localparam int HI_W = REG_W - CNT_W;

  logic             tick;
  logic             halt_q, nmi_q, nr_q;
  logic [REG_W-1:0] ctl2_q;
  logic [CNT_W-1:0] init_q;
  logic [HI_W-1:0]  init_hi_q;
  logic [CNT_W-1:0] count;
  logic             to_flag, sec_flag, boot_flag;
  logic             reload_wr, sts1_wr, sts2_wr, ctl1_wr, ctl2_wr, init_wr;
  logic             suppress;

  assign reload_wr = we_i && (addr_i == A_RELOAD);
  assign sts1_wr   = we_i && (addr_i == A_STS1);
  assign sts2_wr   = we_i && (addr_i == A_STS2);
  assign ctl1_wr   = we_i && (addr_i == A_CTL1);
  assign ctl2_wr   = we_i && (addr_i == A_CTL2);
  assign init_wr   = we_i && (addr_i == A_INIT);
  assign suppress  = no_reboot_i | nr_q;

  wdt_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  wdt_core #(.CNT_W(CNT_W), .INIT_RST(MIN_INIT)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .halt_i    (halt_q),
    .reload_i  (reload_wr),
    .init_i    (init_q),
    .suppress_i(suppress),
    .clr_to_i  (sts1_wr && wdata_i[B_TO]),
    .clr_sec_i (sts2_wr && wdata_i[B_SEC]),
    .clr_boot_i(sts2_wr && wdata_i[B_BOOT]),
    .count_o   (count),
    .to_o      (to_flag),
    .sec_o     (sec_flag),
    .boot_o    (boot_flag),
    .req_o     (reset_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q    <= 1'b1;
      nmi_q     <= 1'b0;
      nr_q      <= 1'b1;
      ctl2_q    <= '0;
      init_q    <= CNT_W'(MIN_INIT);
      init_hi_q <= '0;
    end else begin
      if (ctl1_wr) begin
        halt_q <= wdata_i[B_HALT];
        nr_q   <= wdata_i[B_NR];
        nmi_q  <= nmi_q ^ wdata_i[B_NMI];
      end
      if (ctl2_wr) ctl2_q <= wdata_i;
      if (init_wr) begin
        init_hi_q <= wdata_i[REG_W-1:CNT_W];
        if (wdata_i[CNT_W-1:0] >= CNT_W'(MIN_INIT)) init_q <= wdata_i[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_RELOAD: rdata_o[CNT_W-1:0] = count;
      A_STS1:   rdata_o[B_TO] = to_flag;
      A_STS2: begin
        rdata_o[B_SEC]  = sec_flag;
        rdata_o[B_BOOT] = boot_flag;
      end
      A_CTL1: begin
        rdata_o[B_HALT] = halt_q;
        rdata_o[B_NMI]  = nmi_q;
        rdata_o[B_NR]   = nr_q;
      end
      A_CTL2:   rdata_o = ctl2_q;
      A_INIT:   rdata_o = {init_hi_q, init_q};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_twostage_chk.sv
module wdt_twostage_chk #(
  parameter int CNT_W    = 10,
  parameter int MIN_INIT = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req,
  input logic             suppress,
  input logic             halt,
  input logic             reload,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] init,
  input logic             to_flag,
  input logic             sec_flag,
  input logic             boot_flag
);
  p_req_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req |=> !req);

  p_req_sets_boot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req |-> boot_flag && sec_flag);

  p_suppress_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suppress |=> !req);

  p_halt_freezes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !reload) |=> $stable(count));

  p_reload_loads_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |=> (count == $past(init)));

  p_init_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init >= CNT_W'(MIN_INIT));

  p_second_after_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sec_flag) |-> $past(to_flag));
endmodule

bind wdt_twostage wdt_twostage_chk #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req      (reset_req_o),
  .suppress (suppress),
  .halt     (halt_q),
  .reload   (reload_wr),
  .count    (count),
  .init     (init_q),
  .to_flag  (to_flag),
  .sec_flag (sec_flag),
  .boot_flag(boot_flag)
);

// File: tb/sim_wdt_twostage.sv
module sim_wdt_twostage;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [15:0] rdata_o;
  logic        no_reboot_i = 1'b0;
  logic        reset_req_o;

  int n_chk = 0, n_fail = 0, pulses = 0, cyc = 0;
  logic [4:0]  exp_addr_q[$];
  logic [15:0] exp_data_q[$];
  string       exp_tag_q[$];
  bit          rd_pend = 0;
  bit          done = 0;

  always #5 clk_i = ~clk_i;

  wdt_twostage #(.TICK_DIV(4), .CNT_W(10), .MIN_INIT(4)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .rdata_o(rdata_o), .no_reboot_i(no_reboot_i),
    .reset_req_o(reset_req_o)
  );

  always @(posedge clk_i) if (rst_ni) cyc <= cyc + 1;
  always @(negedge clk_i) if (rst_ni && reset_req_o) pulses++;

  // monitor: pops expected reads and compares
  always @(negedge clk_i) begin
    #1;
    if (rd_pend) begin
      logic [4:0]  a;
      logic [15:0] e;
      string       t;
      a = exp_addr_q.pop_front();
      e = exp_data_q.pop_front();
      t = exp_tag_q.pop_front();
      n_chk++;
      if (rdata_o !== e) begin
        n_fail++;
        $display("FAIL %s addr=0x%02h actual=0x%04h expected=0x%04h", t, a, rdata_o, e);
      end
      rd_pend = 0;
    end
  end

  task automatic rd_exp(input logic [4:0] a, input logic [15:0] e, input string t);
    addr_i = a;
    exp_addr_q.push_back(a);
    exp_data_q.push_back(e);
    exp_tag_q.push_back(t);
    rd_pend = 1;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic chk(input string t, input int act, input int e);
    n_chk++;
    if (act != e) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset state
    rd_exp(5'h00, 16'h0004, "R1 count");
    rd_exp(5'h04, 16'h0000, "R1 sts1");
    rd_exp(5'h06, 16'h0000, "R1 sts2");
    rd_exp(5'h08, 16'h0801, "R1 ctl1");
    rd_exp(5'h12, 16'h0004, "R1 init");
    chk("R1 reset_req low", int'(reset_req_o), 0);
    // R5 initial value field
    wr(5'h12, 16'h0002);  rd_exp(5'h12, 16'h0004, "R5 low value ignored");
    wr(5'h12, 16'hFC0A);  rd_exp(5'h12, 16'hFC0A, "R5 full write");
    wr(5'h12, 16'h0401);  rd_exp(5'h12, 16'h040A, "R5 high kept low ignored");
    wr(5'h12, 16'h000A);  rd_exp(5'h12, 16'h000A, "R5 init 10");
    // R4 reload
    wr(5'h00, 16'h0000);  rd_exp(5'h00, 16'h000A, "R4 reload");
    // R2 exact tick count: align to a tick boundary, run, re-halt
    while (cyc % 4 != 0) @(negedge clk_i);
    wr(5'h08, 16'h0001);
    idle(12);
    wr(5'h08, 16'h0801);
    rd_exp(5'h00, 16'h0007, "R2 three ticks");
    idle(20);
    rd_exp(5'h00, 16'h0007, "R3 halted count frozen");
    rd_exp(5'h08, 16'h0801, "R3 halt readback");
    wr(5'h00, 16'h1234);  rd_exp(5'h00, 16'h000A, "R4 reload any data");
    // R10 toggle bit
    wr(5'h08, 16'h0901);  rd_exp(5'h08, 16'h0901, "R10 toggle on");
    wr(5'h08, 16'h0801);  rd_exp(5'h08, 16'h0901, "R10 zero keeps");
    wr(5'h08, 16'h0901);  rd_exp(5'h08, 16'h0801, "R10 toggle off");
    rd_exp(5'h00, 16'h000A, "R10 no effect on count");
    // R11
    wr(5'h0A, 16'hA5C3);  rd_exp(5'h0A, 16'hA5C3, "R11 ctl2");
    rd_exp(5'h0C, 16'h0000, "R11 unmapped");
    rd_exp(5'h1E, 16'h0000, "R11 unmapped high");

    // two-stage expiry, suppressed by control bit
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'h0001);
    idle(62);
    rd_exp(5'h04, 16'h0008, "R6 first expiry flag");
    rd_exp(5'h06, 16'h0000, "R6 no second yet");
    idle(40);
    rd_exp(5'h06, 16'h0002, "R8 bit suppress second flag, no boot");
    chk("R8 bit suppress no pulse", pulses, 0);
    wr(5'h08, 16'h0801);
    // R9 write-one-to-clear
    wr(5'h06, 16'h0000);  rd_exp(5'h06, 16'h0002, "R9 zero keeps sts2");
    wr(5'h04, 16'h0000);  rd_exp(5'h04, 16'h0008, "R9 zero keeps sts1");
    wr(5'h06, 16'h0002);  rd_exp(5'h06, 16'h0000, "R9 clear second");
    wr(5'h04, 16'h0008);  rd_exp(5'h04, 16'h0000, "R9 clear timeout");

    // unsuppressed: reset request fires once
    no_reboot_i = 1'b0;
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'h0000);
    idle(62);
    rd_exp(5'h04, 16'h0008, "R6 first expiry flag run2");
    chk("R7 no pulse on first expiry", pulses, 0);
    idle(40);
    rd_exp(5'h06, 16'h0006, "R7 second and boot flags");
    chk("R7 one reset pulse", pulses, 1);
    wr(5'h08, 16'h0800);
    wr(5'h06, 16'h0004);  rd_exp(5'h06, 16'h0002, "R9 clear boot only");
    wr(5'h06, 16'h0006);
    wr(5'h04, 16'h0008);
    rd_exp(5'h06, 16'h0000, "R9 sts2 cleared");

    // suppressed by input
    no_reboot_i = 1'b1;
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'h0000);
    idle(62);
    rd_exp(5'h04, 16'h0008, "R8 input suppress first flag");
    idle(40);
    rd_exp(5'h06, 16'h0002, "R8 input suppress second flag no boot");
    chk("R8 input suppress no pulse", pulses, 1);
    wr(5'h08, 16'h0800);
    wr(5'h06, 16'h0006);
    wr(5'h04, 16'h0008);

    // clearing between expiries restarts the two stages
    no_reboot_i = 1'b0;
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'h0000);
    idle(62);
    rd_exp(5'h04, 16'h0008, "R6 first expiry run4");
    wr(5'h04, 16'h0008);
    idle(40);
    rd_exp(5'h06, 16'h0000, "R6 cleared flag gives first stage again");
    rd_exp(5'h04, 16'h0008, "R6 timeout flag set again");
    chk("R6 no pulse after clear", pulses, 1);
    wr(5'h08, 16'h0800);
    idle(2);
    finish_run();
  end
endmodule